// File: doc/BRIEF.md
# Out-of-Order Issue Buffer

This block sits between instruction decode and a group of functional units whose latencies differ. It holds a few decoded instructions and dispatches at most one of them each cycle. The chosen instruction is the oldest one whose source registers have no outstanding write. Decode writes each instruction into the buffer directly. The block does no register renaming, so it has to stop decode from creating hazards the buffer cannot resolve. An instruction is held back when its destination is still being written by an earlier instruction, or when its destination is a source of a buffered instruction that has not yet dispatched.

A pending-write bit is kept for every architectural register. The bit is set when a writer is accepted and cleared by the writeback port. Every buffered entry keeps its own readiness bits for its two sources. The writeback updates these bits, and it also bypasses into the dispatch decision and the decode hazard checks in the same cycle. Source operands are considered read at dispatch, so a slot and its read hazards are released in the cycle the entry leaves.

Top module: `ooo_issue_buf`

## Requirements
- R1: After reset the buffer is empty, no register is pending, `disp_valid_o` is low and `dec_ready_o` is high.
- R2: When every slot holds an entry and none dispatches in this cycle, `dec_ready_o` is low.
- R3: `dec_ready_o` is low while the decode destination has a pending writer, meaning a writer that was accepted and has had no writeback. A writeback to that register in the same cycle lifts this stall.
- R4: `dec_ready_o` is low while the decode destination equals either source of a buffered entry that is not dispatching in this cycle.
- R5: An entry is eligible for dispatch only when neither source has a pending writer. A source counts as ready if it had no pending writer when the entry was accepted, or if that register has been written back since. A younger eligible entry may dispatch ahead of older entries that are not eligible.
- R6: At most one entry dispatches per cycle. `disp_valid_o` is high exactly when at least one buffered entry is eligible.
- R7: When several entries are eligible, the one accepted earliest dispatches.
- R8: A writeback to a register makes entries that read it eligible in the same cycle.
- R9: A dispatching entry frees its slot and its read hazards in that same cycle, so decode may be accepted into a full buffer, or over a WAR conflict with that entry.
- R10: The dispatch outputs carry the operation code, destination and sources unchanged from the accepted decode inputs.
- R11: An instruction whose source equals its own destination is not blocked by its own pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode offers an instruction |
| dec_op_i | input | OP_W | Operation code |
| dec_dst_i | input | $clog2(N_REGS) | Destination register |
| dec_src1_i | input | $clog2(N_REGS) | First source register |
| dec_src2_i | input | $clog2(N_REGS) | Second source register |
| dec_ready_o | output | 1 | Offered instruction is accepted this cycle |
| wb_valid_i | input | 1 | A functional unit writes back |
| wb_dst_i | input | $clog2(N_REGS) | Register being written back |
| disp_valid_o | output | 1 | An instruction is dispatched this cycle |
| disp_op_o | output | OP_W | Dispatched operation code |
| disp_dst_o | output | $clog2(N_REGS) | Dispatched destination |
| disp_src1_o | output | $clog2(N_REGS) | Dispatched first source |
| disp_src2_o | output | $clog2(N_REGS) | Dispatched second source |

## Verification
The bench targets the same-cycle interactions. In one of these a writeback meets a stalled writer. A design without the bypass loses a cycle, and a design that ignores the pending bit lets two writers overlap. In another, a writeback releases a waiting reader while a WAR-blocked writer sits at decode. A design that ignores the dispatching slot stalls for one cycle, and a design that skips the WAR check overwrites a source before it is read. Further cases are age order among readers released by one writeback (a wrong selector dispatches the younger entry first), a full buffer that frees its slot through dispatch, and an instruction that reads its own destination, which deadlocks if its own write is counted against it.

// File: rtl/ooo_issue_pkg.sv
package ooo_issue_pkg;
  parameter int unsigned DEF_ENTRIES = 4;
  parameter int unsigned DEF_REGS    = 8;
  parameter int unsigned DEF_OP_W    = 4;
endpackage

// File: rtl/ooo_reg_pending.sv
module ooo_reg_pending #(
  parameter int unsigned N_REGS = 8,
  localparam int unsigned RW = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic [RW-1:0]     set_idx_i,
  input  logic              clr_en_i,
  input  logic [RW-1:0]     clr_idx_i,
  output logic [N_REGS-1:0] pend_o
);
  logic [N_REGS-1:0] pend_q;

  // set wins: a new writer accepted in the cycle the old one retires
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[r] <= 1'b0;
      else if (set_en_i && set_idx_i == RW'(r)) pend_q[r] <= 1'b1;
      else if (clr_en_i && clr_idx_i == RW'(r)) pend_q[r] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ooo_free_pick.sv
module ooo_free_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] pick_oh_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign pick_oh_o[i] = free_i[i] && !seen[i];
    assign seen[i+1]    = seen[i] || free_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/ooo_oldest_sel.sv
module ooo_oldest_sel #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ins_en_i,
  input  logic [N-1:0] ins_oh_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         gnt_any_o
);
  // older_q[i][j]: entry i was accepted before entry j
  logic [N-1:0][N-1:0] older_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) older_q[i][j] <= 1'b0;
          else         older_q[i][j] <= 1'b0;
        end
      end else begin : g_off
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) older_q[i][j] <= 1'b0;
          else if (ins_en_i && ins_oh_i[j]) older_q[i][j] <= 1'b1;
          else if (ins_en_i && ins_oh_i[i]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    logic [N-1:0] beaten;
    for (genvar j = 0; j < N; j++) begin : g_cmp
      assign beaten[j] = (i != j) && req_i[j] && older_q[j][i];
    end
    assign gnt_o[i] = req_i[i] && !(|beaten);
  end

  assign gnt_any_o = |req_i;
endmodule

// File: rtl/ooo_issue_buf.sv
module ooo_issue_buf
  import ooo_issue_pkg::*;
#(
  parameter int unsigned N_ENT  = DEF_ENTRIES,
  parameter int unsigned N_REGS = DEF_REGS,
  parameter int unsigned OP_W   = DEF_OP_W,
  localparam int unsigned RW = $clog2(N_REGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_valid_i,
  input  logic [OP_W-1:0] dec_op_i,
  input  logic [RW-1:0]   dec_dst_i,
  input  logic [RW-1:0]   dec_src1_i,
  input  logic [RW-1:0]   dec_src2_i,
  output logic            dec_ready_o,
  input  logic            wb_valid_i,
  input  logic [RW-1:0]   wb_dst_i,
  output logic            disp_valid_o,
  output logic [OP_W-1:0] disp_op_o,
  output logic [RW-1:0]   disp_dst_o,
  output logic [RW-1:0]   disp_src1_o,
  output logic [RW-1:0]   disp_src2_o
);
  logic [N_ENT-1:0]           v_q, p1_q, p2_q;
  logic [N_ENT-1:0][OP_W-1:0] op_q;
  logic [N_ENT-1:0][RW-1:0]   dst_q, s1_q, s2_q;

  logic [N_ENT-1:0] hit1, hit2, elig, gnt, war_hit, pick_oh, free_vec;
  logic [N_REGS-1:0] pend;
  logic any_free, gnt_any, waw, accept, ins_p1, ins_p2;

  // per-entry eligibility with writeback bypass
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign hit1[i]    = wb_valid_i && wb_dst_i == s1_q[i];
    assign hit2[i]    = wb_valid_i && wb_dst_i == s2_q[i];
    assign elig[i]    = v_q[i] && (p1_q[i] || hit1[i]) && (p2_q[i] || hit2[i]);
    assign war_hit[i] = v_q[i] && !gnt[i] &&
                        (s1_q[i] == dec_dst_i || s2_q[i] == dec_dst_i);
  end

  ooo_oldest_sel #(.N(N_ENT)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_en_i  (accept),
    .ins_oh_i  (pick_oh),
    .req_i     (elig),
    .gnt_o     (gnt),
    .gnt_any_o (gnt_any)
  );

  assign free_vec = ~v_q | gnt;

  ooo_free_pick #(.N(N_ENT)) u_pick (
    .free_i    (free_vec),
    .pick_oh_o (pick_oh),
    .any_o     (any_free)
  );

  ooo_reg_pending #(.N_REGS(N_REGS)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (accept),
    .set_idx_i (dec_dst_i),
    .clr_en_i  (wb_valid_i),
    .clr_idx_i (wb_dst_i),
    .pend_o    (pend)
  );

  assign waw         = pend[dec_dst_i] && !(wb_valid_i && wb_dst_i == dec_dst_i);
  assign dec_ready_o = any_free && !waw && !(|war_hit);
  assign accept      = dec_valid_i && dec_ready_o;
  assign ins_p1      = !pend[dec_src1_i] || (wb_valid_i && wb_dst_i == dec_src1_i);
  assign ins_p2      = !pend[dec_src2_i] || (wb_valid_i && wb_dst_i == dec_src2_i);

  always_comb begin
    disp_op_o   = '0;
    disp_dst_o  = '0;
    disp_src1_o = '0;
    disp_src2_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (gnt[i]) begin
        disp_op_o   = op_q[i];
        disp_dst_o  = dst_q[i];
        disp_src1_o = s1_q[i];
        disp_src2_o = s2_q[i];
      end
    end
  end
  assign disp_valid_o = gnt_any;

  for (genvar i = 0; i < N_ENT; i++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[i]   <= 1'b0;
        p1_q[i]  <= 1'b0;
        p2_q[i]  <= 1'b0;
        op_q[i]  <= '0;
        dst_q[i] <= '0;
        s1_q[i]  <= '0;
        s2_q[i]  <= '0;
      end else if (accept && pick_oh[i]) begin
        v_q[i]   <= 1'b1;
        p1_q[i]  <= ins_p1;
        p2_q[i]  <= ins_p2;
        op_q[i]  <= dec_op_i;
        dst_q[i] <= dec_dst_i;
        s1_q[i]  <= dec_src1_i;
        s2_q[i]  <= dec_src2_i;
      end else begin
        if (gnt[i]) v_q[i] <= 1'b0;
        if (hit1[i]) p1_q[i] <= 1'b1;
        if (hit2[i]) p2_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ooo_issue_buf_chk.sv
module ooo_issue_buf_chk #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned N_REGS = 8,
  parameter int unsigned OP_W   = 4,
  localparam int unsigned RW = $clog2(N_REGS),
  localparam int unsigned CW = $clog2(N_ENT + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dec_valid_i,
  input logic [OP_W-1:0] dec_op_i,
  input logic [RW-1:0]   dec_dst_i,
  input logic [RW-1:0]   dec_src1_i,
  input logic [RW-1:0]   dec_src2_i,
  input logic            dec_ready_o,
  input logic            wb_valid_i,
  input logic [RW-1:0]   wb_dst_i,
  input logic            disp_valid_o,
  input logic [OP_W-1:0] disp_op_o,
  input logic [RW-1:0]   disp_dst_o,
  input logic [RW-1:0]   disp_src1_o,
  input logic [RW-1:0]   disp_src2_o
);
  logic [CW-1:0]     occ_q;
  logic [N_REGS-1:0] shadow_q;
  logic              acc;

  assign acc = dec_valid_i && dec_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q    <= '0;
      shadow_q <= '0;
    end else begin
      occ_q <= occ_q + CW'(acc) - CW'(disp_valid_o);
      for (int r = 0; r < N_REGS; r++) begin
        if (acc && dec_dst_i == RW'(r))             shadow_q[r] <= 1'b1;
        else if (wb_valid_i && wb_dst_i == RW'(r))  shadow_q[r] <= 1'b0;
      end
    end
  end

  // R2
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == CW'(N_ENT) && !disp_valid_o) |-> !dec_ready_o);

  // R3
  waw_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_q[dec_dst_i] && !(wb_valid_i && wb_dst_i == dec_dst_i)) |-> !dec_ready_o);

  // R5
  raw_src1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_src1_o != disp_dst_o) |->
      (!shadow_q[disp_src1_o] || (wb_valid_i && wb_dst_i == disp_src1_o)));

  // R5
  raw_src2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_src2_o != disp_dst_o) |->
      (!shadow_q[disp_src2_o] || (wb_valid_i && wb_dst_i == disp_src2_o)));

  // R6
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> !disp_valid_o);
endmodule

bind ooo_issue_buf ooo_issue_buf_chk #(
  .N_ENT(N_ENT), .N_REGS(N_REGS), .OP_W(OP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dec_valid_i(dec_valid_i), .dec_op_i(dec_op_i),
  .dec_dst_i(dec_dst_i), .dec_src1_i(dec_src1_i), .dec_src2_i(dec_src2_i),
  .dec_ready_o(dec_ready_o), .wb_valid_i(wb_valid_i), .wb_dst_i(wb_dst_i),
  .disp_valid_o(disp_valid_o), .disp_op_o(disp_op_o), .disp_dst_o(disp_dst_o),
  .disp_src1_o(disp_src1_o), .disp_src2_o(disp_src2_o)
);

// File: tb/ooo_issue_buf_bench.sv
module ooo_issue_buf_bench;
  localparam int NE = 4;
  localparam int NR = 8;
  localparam int OW = 4;
  localparam int RW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dv = 1'b0, wv = 1'b0;
  logic [OW-1:0] dop = '0;
  logic [RW-1:0] dd = '0, ds1 = '0, ds2 = '0, wd = '0;
  logic dec_ready, disp_valid;
  logic [OW-1:0] disp_op;
  logic [RW-1:0] disp_dst, disp_s1, disp_s2;

  always #2 clk = ~clk;

  ooo_issue_buf #(.N_ENT(NE), .N_REGS(NR), .OP_W(OW)) u_ooo_issue_buf (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv), .dec_op_i(dop),
    .dec_dst_i(dd), .dec_src1_i(ds1), .dec_src2_i(ds2), .dec_ready_o(dec_ready),
    .wb_valid_i(wv), .wb_dst_i(wd), .disp_valid_o(disp_valid), .disp_op_o(disp_op),
    .disp_dst_o(disp_dst), .disp_src1_o(disp_s1), .disp_src2_o(disp_s2)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit mv[NE], mp1[NE], mp2[NE];
  int mop[NE], md[NE], ms1[NE], ms2[NE], mseq[NE];
  bit pend[NR], iss[NR];
  int lat[NR];
  int seqc = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit model_empty();
    for (int i = 0; i < NE; i++) if (mv[i]) return 0;
    for (int r = 0; r < NR; r++) if (pend[r]) return 0;
    return 1;
  endfunction

  task automatic step(bit v, int op, int d, int s1, int s2, bit w, int wdst, string tag);
    int sel;
    bit free_any, waw, war, er, acc, hit1, hit2;
    @(posedge clk);
    #1;
    dv = v; dop = OW'(op); dd = RW'(d); ds1 = RW'(s1); ds2 = RW'(s2);
    wv = w; wd = RW'(wdst);
    #1;
    sel = -1;
    for (int i = 0; i < NE; i++) begin
      hit1 = w && wdst == ms1[i];
      hit2 = w && wdst == ms2[i];
      if (mv[i] && (mp1[i] || hit1) && (mp2[i] || hit2))
        if (sel < 0 || mseq[i] < mseq[sel]) sel = i;
    end
    free_any = (sel >= 0);
    for (int i = 0; i < NE; i++) if (!mv[i]) free_any = 1;
    waw = pend[d] && !(w && wdst == d);
    war = 0;
    for (int i = 0; i < NE; i++)
      if (mv[i] && i != sel && (ms1[i] == d || ms2[i] == d)) war = 1;
    er = free_any && !waw && !war;
    chk(tag, "dec_ready", int'(dec_ready), int'(er));
    chk(tag, "disp_valid(R6)", int'(disp_valid), int'(sel >= 0));
    if (sel >= 0 && disp_valid) begin
      chk(tag, "disp_op(R10)", int'(disp_op), mop[sel]);
      chk(tag, "disp_dst(R7)", int'(disp_dst), md[sel]);
      chk(tag, "disp_src1(R10)", int'(disp_s1), ms1[sel]);
      chk(tag, "disp_src2(R10)", int'(disp_s2), ms2[sel]);
    end
    acc = v && er;
    if (sel >= 0) begin
      mv[sel] = 0;
      iss[md[sel]] = 1;
      lat[md[sel]] = $urandom_range(0, 3);
    end
    if (w) begin
      pend[wdst] = 0;
      iss[wdst] = 0;
      for (int i = 0; i < NE; i++) begin
        if (mv[i] && ms1[i] == wdst) mp1[i] = 1;
        if (mv[i] && ms2[i] == wdst) mp2[i] = 1;
      end
    end
    if (acc) begin
      for (int i = 0; i < NE; i++) begin
        if (!mv[i]) begin
          mv[i] = 1; mop[i] = op; md[i] = d; ms1[i] = s1; ms2[i] = s2;
          mp1[i] = !pend[s1]; mp2[i] = !pend[s2]; mseq[i] = seqc++;
          break;
        end
      end
      pend[d] = 1;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 200; k++) begin
      int r;
      if (model_empty()) break;
      r = -1;
      for (int q = 0; q < NR; q++) if (iss[q] && r < 0) r = q;
      step(0, 0, 0, 0, 0, r >= 0, (r >= 0) ? r : 0, "R6");
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    // R3: second writer of r1 stalls until r1 writes back (bypass)
    step(1, 1, 1, 2, 3, 0, 0, "R10");
    step(1, 2, 1, 4, 5, 0, 0, "R3");
    step(1, 2, 1, 4, 5, 1, 1, "R3");
    // R4: writer of r2 blocked by waiting reader of r2; R8/R9 release
    step(1, 3, 4, 1, 2, 0, 0, "R5");
    step(1, 4, 2, 5, 5, 0, 0, "R4");
    step(1, 4, 2, 5, 5, 1, 1, "R8");
    drain();
    // R7: two readers released by one writeback, older first; R5 younger bypass
    step(1, 5, 7, 0, 0, 0, 0, "R7");
    step(1, 6, 5, 7, 0, 0, 0, "R7");
    step(1, 7, 3, 7, 0, 0, 0, "R7");
    step(1, 8, 6, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 7, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    drain();
    // R2: full buffer stalls; R9: slot freed by dispatch
    step(1, 9, 7, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 7, 0, 0, 0, "R2");
    step(1, 2, 2, 7, 0, 0, 0, "R2");
    step(1, 3, 3, 7, 0, 0, 0, "R2");
    step(1, 4, 4, 7, 0, 0, 0, "R2");
    step(1, 5, 5, 0, 0, 0, 0, "R2");
    step(1, 5, 5, 0, 0, 1, 7, "R9");
    drain();
    // R11: reads own destination
    step(1, 10, 3, 3, 3, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    drain();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = -1;
      for (int q = 0; q < NR; q++) if (iss[q] && lat[q] == 0 && r < 0) r = q;
      for (int q = 0; q < NR; q++) if (iss[q] && lat[q] > 0) lat[q]--;
      step(($urandom_range(0, 9) < 7), $urandom_range(0, 15), $urandom_range(0, NR - 1),
           $urandom_range(0, NR - 1), $urandom_range(0, NR - 1),
           r >= 0, (r >= 0) ? r : 0, "R5/R6/R7");
    end
    drain();
    step(0, 0, 0, 0, 0, 0, 0, "R1");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule